// File: doc/BRIEF.md
# JTAG Instruction and Data-Register Selector

This block is a boundary-scan test access port with an 8-bit instruction register. A 16-state controller follows TMS on the rising edge of TCK. The opcode that is loaded picks which data register sits between TDI and TDO. TDO is launched on the falling edge and is enabled only while the block is shifting.

The data registers are:
- a one-bit bypass register;
- a seven-cell boundary register that only samples six select pins and one output-enable pin;
- a 32-bit identification register;
- an 8-bit mode register;
- a small multicast-group register;
- placeholder registers standing in for a pseudo-random generator and a 32-bit TCK counter.

The mode and multicast registers drive parallel outputs. Those outputs move only when a data-register update completes under an instruction that selects them.

Every data register shares one 32-bit shift register. The length of that shift path is set by the decoded selection. TDI enters at the top bit of the selected length, and TDO leaves from bit 0.

Top module: `tap_dr_router`

## Requirements
- R1: Five rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. While in Test-Logic-Reset the instruction register holds 0xAA.
- R2: In Capture-IR the instruction shift register loads 0x01. It shifts LSB first with TDI entering bit 7. The new opcode becomes active on the rising edge leaving Update-IR.
- R3: Opcode 0xFF selects a 1-bit bypass path that captures 0.
- R4: Opcodes 0x00 and 0x81 both select the 7-bit boundary path. It captures select pin i into bit i (i = 0..5) and the output-enable pin into bit 6.
- R5: Opcode 0xAA, opcodes 0xE7, 0xC5, 0x84, 0xC6, 0xC3, 0x88, 0x0C, 0x8D, 0x0F and 0x90, and every opcode not named in R3, R4, R6 or R7 select the 32-bit identification path. That path captures 0x0FC0E01F.
- R6: Opcode 0x8E selects the 8-bit mode path and 0x03 the 3-bit multicast path. Each captures its current parallel output value.
- R7: Opcode 0xC9 selects a 16-bit placeholder that resets to 0xACE1. Opcode 0xCE selects a 32-bit placeholder that resets to 0. Each captures its held value.
- R8: The mode and multicast outputs change only on the edge leaving Update-DR, and only when the active opcode selects that register. They then take the low bits of the shift path.
- R9: TDO and its enable change only on falling TCK edges. The enable is high only in Shift-IR and Shift-DR. TDO carries bit 0 of the register being shifted.
- R10: An active-low asynchronous reset puts the controller in Test-Logic-Reset with opcode 0xAA, clears mode and multicast, and drives TDO and its enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Test mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| sel_pins | input | 6 | Select pins sampled by boundary cells 0..5 |
| oe_pin | input | 1 | Output-enable pin sampled by boundary cell 6 |
| tdo | output | 1 | Serial data out, falling-edge launched |
| tdo_en | output | 1 | High while TDO is driven |
| mode_out | output | 8 | Mode register parallel value |
| mcast_out | output | 3 | Multicast group parallel value |

## Verification
All controller actions land on the rising edge that leaves a state. A captured value appears on TDO after the next falling edge, one bit per cycle. The parallel outputs settle on the rising edge that leaves Update-DR. The bench changes TMS and TDI one nanosecond after each falling edge and reads TDO at that same point, which is the bit about to be shifted. It reads the parallel outputs only after the controller has returned to Run-Test/Idle. To show that TDO never moves on a rising edge, it also compares TDO one nanosecond after each rising edge with the value read in the low phase before it.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W   = 8;
    localparam int DR_MAX = 32;
    localparam int CNT_W  = 32;

    typedef enum logic [3:0] {
        TAP_TLR, TAP_RTI,
        TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
        TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        DR_BYP, DR_BSR, DR_ID, DR_MODE, DR_MCAST, DR_PRBS, DR_CNT
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_RESET   = 8'hAA;
    localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

    function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
        case (op)
            8'hFF:        return DR_BYP;
            8'h00, 8'h81: return DR_BSR;
            8'h8E:        return DR_MODE;
            8'h03:        return DR_MCAST;
            8'hC9:        return DR_PRBS;
            8'hCE:        return DR_CNT;
            default:      return DR_ID;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e st_d, st_q;

    always_comb begin
        unique case (st_q)
            TAP_TLR:    st_d = tms ? TAP_TLR    : TAP_RTI;
            TAP_RTI:    st_d = tms ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_DR: st_d = tms ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: st_d = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  st_d = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: st_d = tms ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: st_d = tms ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: st_d = tms ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: st_d = tms ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_IR: st_d = tms ? TAP_TLR    : TAP_CAP_IR;
            TAP_CAP_IR: st_d = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  st_d = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: st_d = tms ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: st_d = tms ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: st_d = tms ? TAP_UPD_IR : TAP_SH_IR;
            TAP_UPD_IR: st_d = tms ? TAP_SEL_DR : TAP_RTI;
            default:    st_d = TAP_TLR;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) st_q <= TAP_TLR;
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic [IR_W-1:0] ir_sr
);
    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] op;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (state)
            TAP_TLR:    r_d.op = OP_RESET;
            TAP_CAP_IR: r_d.sr = IR_CAPTURE;
            TAP_SH_IR:  r_d.sr = {tdi, r_q.sr[IR_W-1:1]};
            TAP_UPD_IR: r_d.op = r_q.sr;
            default:    ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{sr: '0, op: OP_RESET};
        else        r_q <= r_d;
    end

    assign ir    = r_q.op;
    assign ir_sr = r_q.sr;
endmodule

// File: rtl/tap_dr_bank.sv
module tap_dr_bank
    import tap_pkg::*;
#(
    parameter int          NUM_SEL    = 6,
    parameter int          MODE_W     = 8,
    parameter int          MCAST_W    = 3,
    parameter int          PRBS_W     = 16,
    parameter logic [31:0] PRBS_SEED  = 32'h0000_ACE1,
    parameter logic [31:0] ID_VALUE   = 32'h0FC0_E01F
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic               tdi,
    input  logic [NUM_SEL-1:0] sel_pins,
    input  logic               oe_pin,
    output logic               dr_lsb,
    output logic [MODE_W-1:0]  mode_out,
    output logic [MCAST_W-1:0] mcast_out
);
    localparam int BSR_W = NUM_SEL + 1;
    localparam int LEN_W = $clog2(DR_MAX + 1);

    typedef struct packed {
        logic [DR_MAX-1:0]  sr;
        logic [MODE_W-1:0]  mode;
        logic [MCAST_W-1:0] mcast;
        logic [PRBS_W-1:0]  prbs;
        logic [CNT_W-1:0]   cnt;
    } dr_regs_t;

    dr_regs_t          r_d, r_q;
    logic [LEN_W-1:0]  len;
    logic [DR_MAX-1:0] cap;

    always_comb begin
        unique case (sel)
            DR_BYP:   begin len = LEN_W'(1);       cap = '0; end
            DR_BSR:   begin len = LEN_W'(BSR_W);   cap = DR_MAX'({oe_pin, sel_pins}); end
            DR_MODE:  begin len = LEN_W'(MODE_W);  cap = DR_MAX'(r_q.mode); end
            DR_MCAST: begin len = LEN_W'(MCAST_W); cap = DR_MAX'(r_q.mcast); end
            DR_PRBS:  begin len = LEN_W'(PRBS_W);  cap = DR_MAX'(r_q.prbs); end
            DR_CNT:   begin len = LEN_W'(CNT_W);   cap = DR_MAX'(r_q.cnt); end
            default:  begin len = LEN_W'(DR_MAX);  cap = ID_VALUE; end
        endcase
    end

    always_comb begin
        r_d = r_q;
        unique case (state)
            TAP_CAP_DR: r_d.sr = cap;
            TAP_SH_DR: begin
                r_d.sr = r_q.sr >> 1;
                for (int i = 0; i < DR_MAX; i++) begin
                    if (i == int'(len) - 1) r_d.sr[i] = tdi;
                end
            end
            TAP_UPD_DR: begin
                unique case (sel)
                    DR_MODE:  r_d.mode  = r_q.sr[MODE_W-1:0];
                    DR_MCAST: r_d.mcast = r_q.sr[MCAST_W-1:0];
                    DR_PRBS:  r_d.prbs  = r_q.sr[PRBS_W-1:0];
                    DR_CNT:   r_d.cnt   = r_q.sr[CNT_W-1:0];
                    default:  ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{sr: '0, mode: '0, mcast: '0,
                             prbs: PRBS_SEED[PRBS_W-1:0], cnt: '0};
        else        r_q <= r_d;
    end

    assign dr_lsb    = r_q.sr[0];
    assign mode_out  = r_q.mode;
    assign mcast_out = r_q.mcast;
endmodule

// File: rtl/tap_dr_router.sv
module tap_dr_router
    import tap_pkg::*;
#(
    parameter int          NUM_SEL   = 6,
    parameter int          MODE_W    = 8,
    parameter int          MCAST_W   = 3,
    parameter int          PRBS_W    = 16,
    parameter logic [31:0] PRBS_SEED = 32'h0000_ACE1,
    parameter logic [31:0] ID_VALUE  = 32'h0FC0_E01F
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [NUM_SEL-1:0] sel_pins,
    input  logic               oe_pin,
    output logic               tdo,
    output logic               tdo_en,
    output logic [MODE_W-1:0]  mode_out,
    output logic [MCAST_W-1:0] mcast_out
);
    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    tap_state_e      state;
    logic [IR_W-1:0] ir;
    logic [IR_W-1:0] ir_sr;
    dr_sel_e         sel;
    logic            dr_lsb;
    out_regs_t       o_d, o_q;

    tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

    tap_ir u_ir (.tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
                 .ir(ir), .ir_sr(ir_sr));

    assign sel = decode_op(ir);

    tap_dr_bank #(
        .NUM_SEL(NUM_SEL), .MODE_W(MODE_W), .MCAST_W(MCAST_W),
        .PRBS_W(PRBS_W), .PRBS_SEED(PRBS_SEED), .ID_VALUE(ID_VALUE)
    ) u_dr (
        .tck(tck), .rst_n(rst_n), .state(state), .sel(sel), .tdi(tdi),
        .sel_pins(sel_pins), .oe_pin(oe_pin), .dr_lsb(dr_lsb),
        .mode_out(mode_out), .mcast_out(mcast_out)
    );

    always_comb begin
        o_d.en  = (state == TAP_SH_IR) || (state == TAP_SH_DR);
        o_d.tdo = (state == TAP_SH_IR) ? ir_sr[0] :
                  (state == TAP_SH_DR) ? dr_lsb   : 1'b0;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign tdo    = o_q.tdo;
    assign tdo_en = o_q.en;
endmodule

// File: rtl/tap_dr_router_chk.sv
module tap_dr_router_chk
    import tap_pkg::*;
#(
    parameter int MODE_W  = 8,
    parameter int MCAST_W = 3
) (
    input logic               tck,
    input logic               rst_n,
    input logic               tms,
    input tap_state_e         state,
    input logic [IR_W-1:0]    ir,
    input logic [IR_W-1:0]    ir_sr,
    input dr_sel_e            sel,
    input logic               tdo_en,
    input logic [MODE_W-1:0]  mode_out,
    input logic [MCAST_W-1:0] mcast_out
);
    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)          ones_q <= '0;
        else if (!tms)       ones_q <= '0;
        else if (ones_q < 5) ones_q <= ones_q + 3'd1;
    end

    assert_five_ones_tlr_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_q == 3'd5) |-> (state == TAP_TLR));

    assert_tlr_opcode_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TAP_TLR) |=> (ir == OP_RESET));

    assert_ir_update_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TAP_UPD_IR) |=> (ir == $past(ir_sr)));

    assert_mode_gated_R8: assert property (@(posedge tck) disable iff (!rst_n)
        (mode_out != $past(mode_out)) |->
            ($past(state) == TAP_UPD_DR && $past(sel) == DR_MODE));

    assert_mcast_gated_R8: assert property (@(posedge tck) disable iff (!rst_n)
        (mcast_out != $past(mcast_out)) |->
            ($past(state) == TAP_UPD_DR && $past(sel) == DR_MCAST));

    assert_tdo_en_shift_R9: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == (state == TAP_SH_DR || state == TAP_SH_IR));
endmodule

bind tap_dr_router tap_dr_router_chk #(.MODE_W(MODE_W), .MCAST_W(MCAST_W)) u_chk (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(state), .ir(ir), .ir_sr(ir_sr),
    .sel(sel), .tdo_en(tdo_en), .mode_out(mode_out), .mcast_out(mcast_out)
);

// File: tb/sim_tap_dr_router.sv
module sim_tap_dr_router;
    localparam int TCK_PERIOD = 10;
    localparam logic [39:0] PAT = 40'h9C_5A3E_71D6;
    localparam logic [31:0] IDV = 32'h0FC0_E01F;

    typedef struct packed {
        logic [7:0]  op;
        logic [5:0]  len;
        logic [31:0] cap;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'hFF, 6'd1,  32'h0},        '{8'h00, 6'd7,  32'h6D},
        '{8'h81, 6'd7,  32'h6D},       '{8'hAA, 6'd32, IDV},
        '{8'hE7, 6'd32, IDV},          '{8'hC5, 6'd32, IDV},
        '{8'h84, 6'd32, IDV},          '{8'hC6, 6'd32, IDV},
        '{8'hC3, 6'd32, IDV},          '{8'h88, 6'd32, IDV},
        '{8'h0C, 6'd32, IDV},          '{8'h8D, 6'd32, IDV},
        '{8'h0F, 6'd32, IDV},          '{8'h90, 6'd32, IDV},
        '{8'h8E, 6'd8,  32'h0},        '{8'h03, 6'd3,  32'h0},
        '{8'hC9, 6'd16, 32'hACE1},     '{8'hCE, 6'd32, 32'h0},
        '{8'h55, 6'd32, IDV},          '{8'h01, 6'd32, IDV}
    };

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic [5:0] sel_pins = 6'b101101;
    logic       oe_pin = 1'b1;
    logic       tdo, tdo_en;
    logic [7:0] mode_out;
    logic [2:0] mcast_out;

    int nchk = 0;
    int nfail = 0;
    int hold_bad = 0;
    logic en_seen;

    tap_dr_router u0 (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .sel_pins(sel_pins),
        .oe_pin(oe_pin), .tdo(tdo), .tdo_en(tdo_en), .mode_out(mode_out),
        .mcast_out(mcast_out)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic seen);
        @(negedge tck); #1;
        seen = tdo;
        en_seen = tdo_en;
        tms = m;
        tdi = d;
        @(posedge tck); #1;
        if (tdo !== seen) hold_bad++;
    endtask

    task automatic go_rti();
        logic s;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, s);
        step(1'b0, 1'b0, s);
    endtask

    task automatic do_reset();
        @(negedge tck); rst_n = 1'b0; tms = 1'b1;
        @(negedge tck); #2; rst_n = 1'b1;
    endtask

    task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
        logic s;
        step(1'b1, 1'b0, s); step(1'b1, 1'b0, s);
        step(1'b0, 1'b0, s); step(1'b0, 1'b0, s);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i], s);
            cap[i] = s;
        end
        step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din,
                           output logic [63:0] dout, output logic en_first);
        logic s;
        dout = '0;
        step(1'b1, 1'b0, s); step(1'b0, 1'b0, s); step(1'b0, 1'b0, s);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], s);
            dout[i] = s;
            if (i == 0) en_first = en_seen;
        end
        step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);
    endtask

    function automatic logic [39:0] expect_out(input vec_t v);
        logic [39:0] e;
        for (int i = 0; i < 40; i++)
            e[i] = (i < int'(v.len)) ? v.cap[i] : PAT[i - int'(v.len)];
        return e;
    endfunction

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'hFF:        return "R3";
            8'h00, 8'h81: return "R4";
            8'h8E, 8'h03: return "R6";
            8'hC9, 8'hCE: return "R7";
            default:      return "R5";
        endcase
    endfunction

    initial begin
        #(TCK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [63:0] out;
        logic [7:0]  irc;
        logic        enf;
        logic        s;

        // R10: reset state at the ports
        #3;
        check("R10 tdo_en in reset", 64'(tdo_en), 64'd0);
        check("R10 mode_out in reset", 64'(mode_out), 64'd0);
        check("R10 mcast_out in reset", 64'(mcast_out), 64'd0);
        do_reset();
        step(1'b0, 1'b0, s);
        scan_dr(40, 64'(PAT), out, enf);
        check("R10 reset opcode selects ID", out[39:0], expect_out(VECS[3]));
        check("R9 tdo_en high in shift", 64'(enf), 64'd1);
        check("R9 tdo_en low in idle", 64'(tdo_en), 64'd0);

        // opcode table walk
        for (int k = 0; k < NV; k++) begin
            do_reset();
            go_rti();
            load_ir(VECS[k].op, irc);
            scan_dr(40, 64'(PAT), out, enf);
            check(req_of(VECS[k].op), out[39:0], expect_out(VECS[k]));
            check("R8 mode_out after scan", 64'(mode_out),
                  (VECS[k].op == 8'h8E) ? 64'(PAT[39:32]) : 64'd0);
            check("R8 mcast_out after scan", 64'(mcast_out),
                  (VECS[k].op == 8'h03) ? 64'(PAT[39:37]) : 64'd0);
        end

        // R2: Capture-IR pattern
        do_reset();
        go_rti();
        load_ir(8'h8E, irc);
        check("R2 capture-IR pattern", 64'(irc), 64'h01);

        // R6: mode captures its current value
        scan_dr(8, 64'h3C, out, enf);
        check("R6 mode captures zero", out[7:0], 64'h00);
        scan_dr(8, 64'h00, out, enf);
        check("R6 mode captures held 0x3C", out[7:0], 64'h3C);
        check("R8 mode_out cleared by update", 64'(mode_out), 64'h00);
        scan_dr(8, 64'h5A, out, enf);

        // R8: scan under another opcode leaves mode untouched
        load_ir(8'hAA, irc);
        scan_dr(40, 64'(PAT), out, enf);
        check("R8 mode_out unchanged under ID", 64'(mode_out), 64'h5A);

        // R1: five TMS ones return to reset opcode
        load_ir(8'hFF, irc);
        go_rti();
        scan_dr(40, 64'(PAT), out, enf);
        check("R1 TLR restores ID opcode", out[39:0], expect_out(VECS[3]));
        check("R1 mode_out kept through TLR", 64'(mode_out), 64'h5A);

        // R4: boundary sampling with other pin values
        sel_pins = 6'b010010;
        oe_pin = 1'b0;
        load_ir(8'h00, irc);
        scan_dr(7, 64'h0, out, enf);
        check("R4 boundary capture", out[6:0], 64'h12);

        // R9: TDO never moved on a rising edge
        check("R9 tdo held across rising edges", 64'(hold_bad), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule